// File: doc/BRIEF.md
# Reload-Counter PWM Timer

This block is a general-purpose up-counting timer that drives one PWM pin. Software programs a reload value, a compare value and a control word through a single-cycle register port. The counter climbs toward all-ones and wraps back to the reload value. The distance from the reload value to all-ones sets the period, and the position of the compare value inside that span sets the duty cycle.

Each counter step is a tick. A tick comes either on every functional clock or, with the prescaler on, once every power-of-two number of clocks. Two events shape the output: overflow and compare hit. Depending on the trigger mode, the output either flips or gives a one-tick pulse on these events. A programmable rest level fixes the pin while the timer is stopped and sets the polarity while it runs. The overflow and compare events also set sticky flags, and software clears a flag by writing 1 to it. The timer can run free with auto-reload or stop itself after one overflow.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset every register reads zero, `pwm_out` is low and `irq_ovf` is low.
- R2: Ticks happen only while the run bit (control bit 0) is set. With prescale enable (control bit 5) clear there is one tick per clock. With it set there is one tick every 2^(N+1) clocks, where N is control bits 4:2, and the first tick comes that many clocks after start.
- R3: Each tick adds one to the counter. A write to offset 0x28 loads the written value into the counter.
- R4: A tick taken while the counter is all-ones is an overflow. It reloads the counter from the reload register (offset 0x2C), sets status bit 1 and raises `irq_ovf`. The period is therefore (all-ones − reload + 1) ticks.
- R5: With compare enable (control bit 6) set, a tick taken while the counter equals the compare register (offset 0x38) sets status bit 0. With compare enable clear, no compare event occurs.
- R6: With auto-reload (control bit 1) clear, an overflow also clears the run bit. The counter then holds the reload value.
- R7: Any write to offset 0x30 copies the reload register into the counter, whatever the data.
- R8: Status (offset 0x18) flags are sticky. Writing 1 to a bit clears only that bit, writing 0 has no effect, and a new event in the same cycle wins over the clear.
- R9: Trigger mode (control bits 11:10) 01 acts on overflow only and 10 acts on overflow and compare. Modes 00 and 11 hold `pwm_out` at the rest level.
- R10: With control bit 12 set (toggle), each active event flips the output. With compare mode 10 the output is away from rest for (all-ones − compare) ticks of every period.
- R11: With control bit 12 clear (pulse), the output leaves the rest level for exactly one tick after each active event.
- R12: Control bit 7 is the rest level. `pwm_out` equals it whenever the run bit is clear, and the running waveform is inverted when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | CNT_W | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |
| irq_ovf | output | 1 | Sticky overflow flag (status bit 1) |

## Verification
The bench places the counter a few steps below all-ones, so the wrap to the reload value and the start of the next period land on known edges. A one-off error in the wrap or in the reload path would move every output transition by a tick. The compare hit is checked on the tick after the counter shows the compare value, which catches a design that compares against the already incremented count. The prescaler is checked at 2 and at 8 clocks per tick, where a shift error would halve or double the count.

One-shot stop, trigger modes 00 and 01, pulse width and an inverted rest level are each driven to the edge where a wrong design would keep running, toggle on compare, stretch the pulse, or show the wrong polarity. Partial write-one-to-clear of the status register shows whether one bit is cleared alone or both are wiped.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    // Register byte offsets (software-visible map)
    localparam int OFS_STAT   = 'h18;
    localparam int OFS_CTRL   = 'h24;
    localparam int OFS_COUNT  = 'h28;
    localparam int OFS_LOAD   = 'h2C;
    localparam int OFS_RELOAD = 'h30;
    localparam int OFS_MATCH  = 'h38;

    // Output trigger selection
    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_OVF  = 2'b01,
        TRIG_BOTH = 2'b10,
        TRIG_RSVD = 2'b11
    } trig_e;

    // Control word, unpacked from the register layout
    typedef struct packed {
        logic       modtgl;   // 1: toggle, 0: pulse
        trig_e      trig;
        logic       idle;     // rest level of the pin
        logic       cmp_en;
        logic       pre_en;
        logic [2:0] ptv;
        logic       autold;   // 1: auto-reload, 0: one-shot
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             pre_en_i,
    input  logic [PTV_W-1:0] ptv_i,
    output logic             tick_o
);
    localparam int DIV_W = 1 << PTV_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [DIV_W:0]   lim_w;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim_w  = ((DIV_W+1)'(2) << ptv_i) - (DIV_W+1)'(1);
        lim    = lim_w[DIV_W-1:0];
        st_d   = st_q;
        tick_o = 1'b0;
        if (!run_i) begin
            st_d.div = '0;
        end else if (!pre_en_i) begin
            tick_o   = 1'b1;
            st_d.div = '0;
        end else if (st_q.div >= lim) begin
            tick_o   = 1'b1;
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // With the divider active, two ticks are never back to back
    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en_i && tick_o) |=> (!tick_o || !pre_en_i)); // R2

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] match_i,
    input  logic             cmp_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = tick_i && (st_q.cnt == {CNT_W{1'b1}});
        hit_o = tick_i && cmp_en_i && (st_q.cnt == match_i);
        if (cnt_we_i) begin
            st_d.cnt = cnt_wdata_i;
        end else if (reload_i) begin
            st_d.cnt = load_i;
        end else if (ovf_o) begin
            st_d.cnt = load_i;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_we_i && !reload_i && (cnt_o != {CNT_W{1'b1}}))
        |=> (cnt_o == $past(cnt_o) + 1'b1)); // R3

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_we_i && !reload_i) |=> $stable(cnt_o)); // R3

    AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !cnt_we_i && !reload_i) |=> (cnt_o == $past(load_i))); // R4

endmodule

// File: rtl/ptmr_wave.sv
module ptmr_wave
    import ptmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  run_i,
    input  trig_e trig_i,
    input  logic  toggle_i,
    input  logic  idle_i,
    input  logic  ovf_i,
    input  logic  hit_i,
    output logic  pwm_o
);
    typedef struct packed {
        logic wave;
    } wave_st_t;

    wave_st_t st_d, st_q;
    logic     active;
    logic     ev;

    always_comb begin
        active = run_i && ((trig_i == TRIG_OVF) || (trig_i == TRIG_BOTH));
        ev     = ovf_i || ((trig_i == TRIG_BOTH) && hit_i);
        st_d   = st_q;
        if (!active) begin
            st_d.wave = 1'b0;
        end else if (tick_i) begin
            if (toggle_i) st_d.wave = st_q.wave ^ ev;
            else          st_d.wave = ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = idle_i ^ (st_q.wave & active);

    // Between ticks the waveform state never moves
    AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick_i) |=> $stable(st_q.wave)); // R10

    // A pulse lasts one tick: a tick without an event ends it
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !toggle_i && tick_i && !ev) |=> !st_q.wave); // R11

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              reg_we,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              pwm_out,
    output logic              irq_ovf
);
    localparam int PTV_W  = 3;
    localparam int STAT_W = 2;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  match;
        logic [STAT_W-1:0] stat;   // [1] overflow, [0] compare hit
    } regs_t;

    regs_t q, d;

    logic wr_ctrl, wr_cnt, wr_load, wr_rld, wr_match, wr_stat;
    logic tick, ovf, hit;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wr_ctrl  = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
        wr_cnt   = reg_we && (reg_addr == ADDR_W'(OFS_COUNT));
        wr_load  = reg_we && (reg_addr == ADDR_W'(OFS_LOAD));
        wr_rld   = reg_we && (reg_addr == ADDR_W'(OFS_RELOAD));
        wr_match = reg_we && (reg_addr == ADDR_W'(OFS_MATCH));
        wr_stat  = reg_we && (reg_addr == ADDR_W'(OFS_STAT));
    end

    // Next-state logic for the register file
    always_comb begin
        d = q;
        if (ovf && !q.ctrl.autold) d.ctrl.run = 1'b0;
        if (wr_ctrl) begin
            d.ctrl.run    = reg_wdata[0];
            d.ctrl.autold = reg_wdata[1];
            d.ctrl.ptv    = reg_wdata[4:2];
            d.ctrl.pre_en = reg_wdata[5];
            d.ctrl.cmp_en = reg_wdata[6];
            d.ctrl.idle   = reg_wdata[7];
            d.ctrl.trig   = trig_e'(reg_wdata[11:10]);
            d.ctrl.modtgl = reg_wdata[12];
        end
        if (wr_load)  d.load  = reg_wdata;
        if (wr_match) d.match = reg_wdata;
        d.stat = (q.stat & ~(wr_stat ? reg_wdata[STAT_W-1:0] : '0)) | {ovf, hit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CTRL)) begin
            reg_rdata[0]     = q.ctrl.run;
            reg_rdata[1]     = q.ctrl.autold;
            reg_rdata[4:2]   = q.ctrl.ptv;
            reg_rdata[5]     = q.ctrl.pre_en;
            reg_rdata[6]     = q.ctrl.cmp_en;
            reg_rdata[7]     = q.ctrl.idle;
            reg_rdata[11:10] = q.ctrl.trig;
            reg_rdata[12]    = q.ctrl.modtgl;
        end else if (reg_addr == ADDR_W'(OFS_COUNT)) begin
            reg_rdata = cnt;
        end else if (reg_addr == ADDR_W'(OFS_LOAD)) begin
            reg_rdata = q.load;
        end else if (reg_addr == ADDR_W'(OFS_MATCH)) begin
            reg_rdata = q.match;
        end else if (reg_addr == ADDR_W'(OFS_STAT)) begin
            reg_rdata[STAT_W-1:0] = q.stat;
        end
    end

    ptmr_prescale #(.PTV_W(PTV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (q.ctrl.run),
        .pre_en_i (q.ctrl.pre_en),
        .ptv_i    (q.ctrl.ptv),
        .tick_o   (tick)
    );

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cnt_we_i    (wr_cnt),
        .cnt_wdata_i (reg_wdata),
        .reload_i    (wr_rld),
        .load_i      (q.load),
        .match_i     (q.match),
        .cmp_en_i    (q.ctrl.cmp_en),
        .cnt_o       (cnt),
        .ovf_o       (ovf),
        .hit_o       (hit)
    );

    ptmr_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .run_i    (q.ctrl.run),
        .trig_i   (q.ctrl.trig),
        .toggle_i (q.ctrl.modtgl),
        .idle_i   (q.ctrl.idle),
        .ovf_i    (ovf),
        .hit_i    (hit),
        .pwm_o    (pwm_out)
    );

    assign irq_ovf = q.stat[1];

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !q.ctrl.autold && !wr_ctrl) |=> !q.ctrl.run); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stat[1] && !(wr_stat && reg_wdata[1])) |=> q.stat[1]); // R8

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl.run |-> (pwm_out == q.ctrl.idle)); // R12

    AST_MODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.trig == TRIG_NONE) |-> (pwm_out == q.ctrl.idle)); // R9

endmodule

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;

    localparam logic [7:0] A_STAT = 8'h18, A_CTRL = 8'h24, A_CNT = 8'h28,
                           A_LOAD = 8'h2C, A_RLD = 8'h30, A_MATCH = 8'h38;
    localparam logic [31:0] C_RUN = 32'h1, C_AR = 32'h2, C_PRE = 32'h20,
                            C_CE = 32'h40, C_IDLE = 32'h80,
                            C_TOVF = 32'h400, C_TBOTH = 32'h800, C_TGL = 32'h1000;
    localparam logic [31:0] BASE = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        pwm_out, irq_ovf;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq_ovf(irq_ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic setup(input logic [31:0] ld, input logic [31:0] cv, input logic [31:0] mt);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h3);
        wr(A_LOAD, ld);
        wr(A_MATCH, mt);
        wr(A_CNT, cv);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_CNT, v);   chk("R1 count", v, 0);
        rd(A_LOAD, v);  chk("R1 load", v, 0);
        rd(A_MATCH, v); chk("R1 match", v, 0);
        rd(A_STAT, v);  chk("R1 status", v, 0);
        chk("R1 pwm", 32'(pwm_out), 0);
        chk("R1 irq", 32'(irq_ovf), 0);
    endtask

    task automatic t_direct_and_reload();
        logic [31:0] v;
        setup(32'h1234, 32'h55, 0);
        rd(A_CNT, v); chk("R3 direct write", v, 32'h55);
        wr(A_RLD, 32'hDEAD_BEEF);
        rd(A_CNT, v); chk("R7 trigger reload", v, 32'h1234);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        setup(BASE, BASE, 0);
        wr(A_CTRL, C_RUN | C_AR);
        for (int k = 1; k <= 5; k++) @(negedge clk);
        rd(A_CNT, v); chk("R3 one tick per clock", v, BASE + 5);
        setup(BASE, BASE, 0);
        wr(A_CTRL, C_RUN | C_AR | C_PRE);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            rd(A_CNT, v); chk("R2 divide by 2", v, BASE + 32'(k / 2));
        end
        setup(BASE, BASE, 0);
        wr(A_CTRL, C_RUN | C_AR | C_PRE | (32'd2 << 2));
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (k == 7 || k == 8 || k == 15 || k == 16) begin
                rd(A_CNT, v); chk("R2 divide by 8", v, BASE + 32'(k / 8));
            end
        end
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        setup(BASE, 32'hFFFF_FFFD, 0);
        wr(A_CTRL, C_RUN | C_AR);
        for (int k = 1; k <= 19; k++) begin
            @(negedge clk);
            if (k == 2) begin
                rd(A_CNT, v); chk("R4 at all-ones", v, 32'hFFFF_FFFF);
                chk("R4 irq before wrap", 32'(irq_ovf), 0);
            end
            if (k == 3) begin
                rd(A_CNT, v); chk("R4 wrap to reload", v, BASE);
                chk("R4 irq after wrap", 32'(irq_ovf), 1);
            end
            if (k == 18) begin rd(A_CNT, v); chk("R4 period end", v, 32'hFFFF_FFFF); end
            if (k == 19) begin rd(A_CNT, v); chk("R4 second wrap", v, BASE); end
        end
    endtask

    task automatic t_match();
        logic [31:0] v;
        setup(BASE, BASE, BASE + 4);
        wr(A_CTRL, C_RUN | C_AR | C_CE);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 4) begin rd(A_STAT, v); chk("R5 no hit yet", v & 1, 0); end
            if (k == 5) begin rd(A_STAT, v); chk("R5 hit flag", v & 1, 1); end
        end
        setup(BASE, BASE, BASE + 4);
        wr(A_CTRL, C_RUN | C_AR);
        for (int k = 1; k <= 20; k++) @(negedge clk);
        rd(A_STAT, v); chk("R5 compare disabled", v & 1, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        setup(BASE, 32'hFFFF_FFFD, 0);
        wr(A_CTRL, C_RUN);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k == 2) begin rd(A_CTRL, v); chk("R6 still running", v & 1, 1); end
            if (k == 3) begin
                rd(A_CTRL, v); chk("R6 run self-clears", v & 1, 0);
                rd(A_CNT, v);  chk("R6 counter at reload", v, BASE);
            end
        end
        rd(A_CNT, v); chk("R6 counter holds", v, BASE);
        chk("R6 irq set", 32'(irq_ovf), 1);
    endtask

    task automatic t_status();
        logic [31:0] v;
        setup(BASE, BASE, BASE + 4);
        wr(A_CTRL, C_RUN | C_AR | C_CE);
        for (int k = 1; k <= 17; k++) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_STAT, v); chk("R8 both flags", v, 3);
        wr(A_STAT, 0);
        rd(A_STAT, v); chk("R8 write zero keeps", v, 3);
        wr(A_STAT, 1);
        rd(A_STAT, v); chk("R8 clear hit only", v, 2);
        chk("R8 irq kept", 32'(irq_ovf), 1);
        wr(A_STAT, 2);
        rd(A_STAT, v); chk("R8 clear overflow", v, 0);
        chk("R8 irq cleared", 32'(irq_ovf), 0);
    endtask

    task automatic t_toggle(input bit inv);
        logic exp;
        setup(BASE, BASE, BASE + 8);
        wr(A_CTRL, C_RUN | C_AR | C_CE | C_TBOTH | C_TGL | (inv ? C_IDLE : 0));
        for (int k = 1; k <= 48; k++) begin
            @(negedge clk);
            exp = ((k % 16) >= 9) ^ inv;
            chk(inv ? "R12 inverted waveform" : "R10 toggle waveform", 32'(pwm_out), 32'(exp));
        end
    endtask

    task automatic t_trig_ovf();
        logic exp;
        setup(BASE, BASE, BASE + 8);
        wr(A_CTRL, C_RUN | C_AR | C_CE | C_TOVF | C_TGL);
        for (int k = 1; k <= 64; k++) begin
            @(negedge clk);
            exp = (k % 32) >= 16;
            chk("R9 overflow-only toggle", 32'(pwm_out), 32'(exp));
        end
    endtask

    task automatic t_trig_none();
        logic [31:0] v;
        setup(BASE, BASE, BASE + 8);
        wr(A_CTRL, C_RUN | C_AR | C_CE | C_TGL);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (pwm_out !== 1'b0) chk("R9 mode 00 holds rest", 32'(pwm_out), 0);
        end
        chk("R9 mode 00 holds rest", 32'(pwm_out), 0);
        rd(A_STAT, v); chk("R9 events still flagged", v, 3);
    endtask

    task automatic t_pulse();
        setup(BASE, 32'hFFFF_FFFE, 0);
        wr(A_CTRL, C_RUN | C_AR | C_TOVF);
        for (int k = 1; k <= 19; k++) begin
            @(negedge clk);
            if (k == 1)  chk("R11 before pulse", 32'(pwm_out), 0);
            if (k == 2)  chk("R11 pulse", 32'(pwm_out), 1);
            if (k == 3)  chk("R11 pulse ends", 32'(pwm_out), 0);
            if (k == 18) chk("R11 next pulse", 32'(pwm_out), 1);
            if (k == 19) chk("R11 next pulse ends", 32'(pwm_out), 0);
        end
    endtask

    task automatic t_idle_stopped();
        wr(A_CTRL, C_IDLE);
        chk("R12 rest high while stopped", 32'(pwm_out), 1);
        wr(A_CTRL, 0);
        chk("R12 rest low while stopped", 32'(pwm_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_and_reload();
        t_prescale();
        t_overflow();
        t_match();
        t_oneshot();
        t_status();
        t_toggle(0);
        t_toggle(1);
        t_trig_ovf();
        t_trig_none();
        t_pulse();
        t_idle_stopped();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule